// File: doc/BRIEF.md
# Hardware Genetic Algorithm Engine

This block runs a generational genetic algorithm entirely in logic. It holds a population of fixed-length bit-vector chromosomes in two register banks. Each chromosome is offered to an external fitness evaluator over a valid/ready request channel, and the evaluator answers each accepted request with a one-cycle score pulse. When a whole generation has been scored, the engine breeds the next one into the idle bank. Breeding copies the best individual into slot 0. It then fills the remaining slots in pairs, using binary-tournament parent selection, a random choice between single-point crossover and cloning, and per-bit mutation. The banks swap only when the new generation is full.

A 32-bit linear feedback shift register, seeded from an input at start, supplies every random decision. The surrounding system sets a clone probability, a mutation probability, a fitness target and a generation limit. It pulses `start`, serves fitness requests, and reads the best chromosome, its score and the generation counter once `done` rises. A `stop` pulse ends the run early at the next generation boundary.

Top module: `ga_engine`

## Requirements
- R1: Each generation issues exactly POP requests in slot order 0..POP-1. `req_data` stays unchanged while `req_valid` is high and `req_ready` is low. Exactly one `fit_valid` pulse is consumed per accepted request.
- R2: `best_fit` is the largest score seen since start, and `best_chrom` is the first chromosome that reached it. A later equal score does not replace it. Both clear to 0 on start, and `best_fit` never decreases during a run.
- R3: Slot 0 of every bred generation is an unchanged copy of the previous generation's highest-scoring chromosome. On a tie, the lowest slot wins.
- R4: A pair is cloned when an 8-bit random value is below `cfg_clone_rate`. A rate of 255 always clones and a rate of 0 never does. Cloned children equal their parents before mutation.
- R5: Crossover uses one cut position k drawn in 1..CHROM_W-1. Child A takes bits [k-1:0] from parent A and the rest from parent B. Child B takes the opposite bits.
- R6: Each child bit is inverted when a fresh 8-bit random value is below `cfg_mut_rate`. A rate of 0 flips nothing and a rate of 255 flips every bit. The elite copy is never mutated.
- R7: Each parent is the winner of a binary tournament between two random slots of the current generation. The higher score wins, and on a tie the lower slot wins.
- R8: When, after a generation is scored, `best_fit` >= `cfg_target`, the run ends. `done` rises, no further requests are made, and outputs hold until the next start.
- R9: When `gen_count` equals `cfg_gen_limit` after a generation is scored, the run ends with `gen_count` equal to the limit. A limit of 0 scores only the initial population.
- R10: A `stop` pulse during a run ends it after the current generation has been scored, with no further breeding.
- R11: After reset, `done` and `req_valid` are 0 and `gen_count`, `best_fit` and `best_chrom` are 0.
- R12: `gen_count` is the index of the generation being scored: 0 for the initial population, rising by one at each bank swap.
- R13: The initial population comes from the random source loaded with `seed` on start, with a zero seed replaced by 1. The same seed reproduces the same initial population.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (accepted when idle or done) |
| stop | input | 1 | End the run at the next generation boundary |
| seed | input | 32 | Random source seed loaded on start |
| cfg_clone_rate | input | 8 | Clone probability threshold |
| cfg_mut_rate | input | 8 | Per-bit mutation probability threshold |
| cfg_target | input | FIT_W | Fitness target ending the run |
| cfg_gen_limit | input | GEN_W | Generation limit ending the run |
| req_valid | output | 1 | A chromosome awaits evaluation |
| req_ready | input | 1 | Evaluator accepts the chromosome |
| req_data | output | CHROM_W | Chromosome to evaluate |
| fit_valid | input | 1 | Score pulse for the accepted chromosome |
| fit_data | input | FIT_W | Score value |
| best_chrom | output | CHROM_W | Best chromosome so far |
| best_fit | output | FIT_W | Score of best_chrom |
| gen_count | output | GEN_W | Current generation index |
| done | output | 1 | Run finished |

## Verification
Several rules are checked on every cycle. The assertions hold a stalled request stable and keep `best_fit` monotonic. They confirm that the generation counter only steps by one and never passes the limit, that tournament winners outscore their opponent, that crossover children carry exactly the parents' bits, and that the random state never reaches zero. The bench scenarios show the population-level behaviour that no single-cycle property captures. With cloning forced and mutation off, every child must be a copy of a member of the previous generation. With cloning and full mutation, every child must be a bitwise complement of one. With cloning off, each child pair must match some parent pair split at a legal cut. The scenarios also check elitism across the swap, the generation at which target, limit or stop ends the run, and replay of the initial population from the seed.

// File: rtl/ga_pkg.sv
// Shared state encoding and the probability draw used by the engine.
// Assumes 8-bit rate thresholds where 255 means "always".
package ga_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_INIT, S_EVAL, S_WAIT, S_CHECK, S_ELITE, S_SEL_A,
        S_SEL_B, S_CROSS, S_MUT, S_WRITE, S_SWAP, S_DONE
    } ga_state_e;

    // True when a random byte falls below the rate; rate 255 is certain.
    function automatic logic draw_below(input logic [7:0] rnd_byte,
                                        input logic [7:0] rate);
        return (rate == 8'hFF) || (rnd_byte < rate);
    endfunction

endpackage

// File: rtl/ga_lfsr.sv
// Free-running 32-bit Galois shift register used as the random source.
// Loads a seed on request; a zero seed is replaced by 1 so it never locks.
module ga_lfsr #(
    parameter logic [31:0] TAPS = 32'h8020_0003
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] seed,
    output logic [31:0] rnd
);

    logic [31:0] state_q;

    // Advance one step per cycle, or load the seed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= 32'd1;
        else if (load)
            state_q <= (seed == 32'd0) ? 32'd1 : seed;
        else
            state_q <= {1'b0, state_q[31:1]} ^ (state_q[0] ? TAPS : 32'd0);
    end

    assign rnd = state_q;

    // R13 and R5: the random source never reaches the all-zero state.
    assert_lfsr_alive_R13: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 32'd0);

endmodule

// File: rtl/ga_tournament.sv
// Binary tournament: picks the higher-scoring of two candidate slots.
// Assumes the caller supplies each candidate's stored score; a tie goes
// to the lower slot index.
module ga_tournament #(
    parameter int FIT_W = 16,
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0] cand_x,
    input  logic [IDX_W-1:0] cand_y,
    input  logic [FIT_W-1:0] fit_x,
    input  logic [FIT_W-1:0] fit_y,
    output logic [IDX_W-1:0] win_idx,
    output logic [FIT_W-1:0] win_fit
);

    // Compare scores, then break ties by slot index.
    always_comb begin
        if (fit_x > fit_y) begin
            win_idx = cand_x;
            win_fit = fit_x;
        end else if (fit_y > fit_x) begin
            win_idx = cand_y;
            win_fit = fit_y;
        end else begin
            win_idx = (cand_x < cand_y) ? cand_x : cand_y;
            win_fit = fit_x;
        end
    end

    // R7: the winner never scores below either candidate.
    always_comb begin
        assert_tourn_winner_R7: assert (win_fit >= fit_x && win_fit >= fit_y)
            else $error("tournament winner below a candidate");
    end

endmodule

// File: rtl/ga_breeder.sv
// Produces a child pair from two parents by single-point crossover or
// by cloning. Assumes cut lies in 1..CHROM_W-1 when crossover is used.
module ga_breeder #(
    parameter int CHROM_W = 16,
    parameter int CUT_W   = 4
) (
    input  logic [CHROM_W-1:0] par_a,
    input  logic [CHROM_W-1:0] par_b,
    input  logic [CUT_W-1:0]   cut,
    input  logic               clone,
    output logic [CHROM_W-1:0] kid_a,
    output logic [CHROM_W-1:0] kid_b
);

    logic [CHROM_W-1:0] low_mask;

    // Build the mask of bit positions below the cut.
    always_comb begin
        for (int i = 0; i < CHROM_W; i++)
            low_mask[i] = (i < int'(cut));
    end

    // Select clone or the two crossover mixes.
    always_comb begin
        if (clone) begin
            kid_a = par_a;
            kid_b = par_b;
        end else begin
            kid_a = (par_a & low_mask) | (par_b & ~low_mask);
            kid_b = (par_b & low_mask) | (par_a & ~low_mask);
        end
    end

    // R5: at every bit position the pair carries exactly the parents' bits.
    always_comb begin
        assert_gene_conserve_R5: assert (((kid_a ^ kid_b) == (par_a ^ par_b)) &&
                                         ((kid_a & kid_b) == (par_a & par_b)))
            else $error("children lost parent genes");
    end

endmodule

// File: rtl/ga_engine.sv
// Generational genetic algorithm engine. Holds two population banks,
// requests a score per chromosome, breeds the next generation into the
// idle bank (elite in slot 0, then tournament, crossover/clone, mutation)
// and swaps banks when full. Assumes POP >= 2, 2 <= CHROM_W <= 32 and
// configuration held stable during a run.
module ga_engine #(
    parameter int CHROM_W = 16,
    parameter int POP     = 8,
    parameter int FIT_W   = 16,
    parameter int GEN_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               stop,
    input  logic [31:0]        seed,
    input  logic [7:0]         cfg_clone_rate,
    input  logic [7:0]         cfg_mut_rate,
    input  logic [FIT_W-1:0]   cfg_target,
    input  logic [GEN_W-1:0]   cfg_gen_limit,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [CHROM_W-1:0] req_data,
    input  logic               fit_valid,
    input  logic [FIT_W-1:0]   fit_data,
    output logic [CHROM_W-1:0] best_chrom,
    output logic [FIT_W-1:0]   best_fit,
    output logic [GEN_W-1:0]   gen_count,
    output logic               done
);
    import ga_pkg::*;

    localparam int IDX_W  = $clog2(POP);
    localparam int OIDX_W = IDX_W + 1;
    localparam int CUT_W  = $clog2(CHROM_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(POP - 1);
    localparam logic [CUT_W-1:0] LAST_BIT = CUT_W'(CHROM_W - 1);

    ga_state_e           state;
    logic                cur;
    logic [IDX_W-1:0]    idx;
    logic [OIDX_W-1:0]   oidx;
    logic [CUT_W-1:0]    bit_idx;
    logic [IDX_W-1:0]    gb_idx;
    logic [FIT_W-1:0]    gb_fit;
    logic [CHROM_W-1:0]  par_a, par_b, c0, c1;
    logic [CUT_W-1:0]    cut_q;
    logic                clone_q;
    logic                stop_pend;

    logic [CHROM_W-1:0]  pop_mem [2][POP];
    logic [FIT_W-1:0]    fit_mem [POP];

    logic                busy, launch;
    logic [31:0]         rnd;
    logic [IDX_W-1:0]    cand_x, cand_y, win_idx;
    logic [FIT_W-1:0]    win_fit;
    logic [CHROM_W-1:0]  brd_a, brd_b;
    logic                flip0, flip1;
    logic [IDX_W-1:0]    wr_idx0, wr_idx1;

    assign busy   = (state != S_IDLE) && (state != S_DONE);
    assign launch = start && !busy;

    ga_lfsr u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (launch),
        .seed  (seed),
        .rnd   (rnd)
    );

    assign cand_x = IDX_W'(rnd % 32'(POP));
    assign cand_y = IDX_W'((rnd >> 8) % 32'(POP));

    ga_tournament #(.FIT_W(FIT_W), .IDX_W(IDX_W)) u_tourn (
        .cand_x  (cand_x),
        .cand_y  (cand_y),
        .fit_x   (fit_mem[cand_x]),
        .fit_y   (fit_mem[cand_y]),
        .win_idx (win_idx),
        .win_fit (win_fit)
    );

    ga_breeder #(.CHROM_W(CHROM_W), .CUT_W(CUT_W)) u_breed (
        .par_a (par_a),
        .par_b (par_b),
        .cut   (cut_q),
        .clone (clone_q),
        .kid_a (brd_a),
        .kid_b (brd_b)
    );

    assign flip0   = draw_below(rnd[7:0],  cfg_mut_rate);
    assign flip1   = draw_below(rnd[15:8], cfg_mut_rate);
    assign wr_idx0 = oidx[IDX_W-1:0];
    assign wr_idx1 = IDX_W'(oidx + 1'b1);

    assign req_valid = (state == S_EVAL);
    assign req_data  = pop_mem[cur][idx];
    assign done      = (state == S_DONE);

    // Population and score storage writes (memory, no reset).
    always_ff @(posedge clk) begin
        case (state)
            S_INIT:  pop_mem[cur][idx] <= rnd[CHROM_W-1:0];
            S_WAIT:  if (fit_valid) fit_mem[idx] <= fit_data;
            S_ELITE: pop_mem[~cur][0] <= pop_mem[cur][gb_idx];
            S_WRITE: begin
                pop_mem[~cur][wr_idx0] <= c0;
                if (int'(oidx) + 1 < POP)
                    pop_mem[~cur][wr_idx1] <= c1;
            end
            default: ;
        endcase
    end

    // Latch a stop request until the next generation boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || launch)
            stop_pend <= 1'b0;
        else if (stop && busy)
            stop_pend <= 1'b1;
    end

    // Main sequencer: initialise, score, decide, breed, swap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            cur        <= 1'b0;
            idx        <= '0;
            oidx       <= '0;
            bit_idx    <= '0;
            gb_idx     <= '0;
            gb_fit     <= '0;
            par_a      <= '0;
            par_b      <= '0;
            c0         <= '0;
            c1         <= '0;
            cut_q      <= '0;
            clone_q    <= 1'b0;
            best_chrom <= '0;
            best_fit   <= '0;
            gen_count  <= '0;
        end else begin
            case (state)
                S_IDLE, S_DONE: if (start) begin
                    state      <= S_INIT;
                    idx        <= '0;
                    best_chrom <= '0;
                    best_fit   <= '0;
                    gen_count  <= '0;
                end
                S_INIT: begin
                    if (idx == LAST_IDX) begin
                        idx   <= '0;
                        state <= S_EVAL;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                S_EVAL: if (req_ready) state <= S_WAIT;
                S_WAIT: if (fit_valid) begin
                    if (fit_data > best_fit) begin
                        best_fit   <= fit_data;
                        best_chrom <= pop_mem[cur][idx];
                    end
                    if (idx == '0 || fit_data > gb_fit) begin
                        gb_idx <= idx;
                        gb_fit <= fit_data;
                    end
                    if (idx == LAST_IDX) begin
                        state <= S_CHECK;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= S_EVAL;
                    end
                end
                S_CHECK: begin
                    if (best_fit >= cfg_target || gen_count >= cfg_gen_limit || stop_pend)
                        state <= S_DONE;
                    else
                        state <= S_ELITE;
                end
                S_ELITE: begin
                    oidx  <= OIDX_W'(1);
                    state <= S_SEL_A;
                end
                S_SEL_A: begin
                    par_a <= pop_mem[cur][win_idx];
                    state <= S_SEL_B;
                end
                S_SEL_B: begin
                    par_b   <= pop_mem[cur][win_idx];
                    clone_q <= draw_below(rnd[23:16], cfg_clone_rate);
                    cut_q   <= CUT_W'(32'd1 + ({24'd0, rnd[31:24]} % 32'(CHROM_W - 1)));
                    state   <= S_CROSS;
                end
                S_CROSS: begin
                    c0      <= brd_a;
                    c1      <= brd_b;
                    bit_idx <= '0;
                    state   <= S_MUT;
                end
                S_MUT: begin
                    c0 <= c0 ^ (CHROM_W'(flip0) << bit_idx);
                    c1 <= c1 ^ (CHROM_W'(flip1) << bit_idx);
                    if (bit_idx == LAST_BIT)
                        state <= S_WRITE;
                    else
                        bit_idx <= bit_idx + 1'b1;
                end
                S_WRITE: begin
                    oidx <= oidx + OIDX_W'(2);
                    if (int'(oidx) + 2 >= POP)
                        state <= S_SWAP;
                    else
                        state <= S_SEL_A;
                end
                S_SWAP: begin
                    cur       <= ~cur;
                    gen_count <= gen_count + 1'b1;
                    idx       <= '0;
                    state     <= S_EVAL;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R1: a stalled request keeps its chromosome.
    assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_data)));

    // R2: the best score never drops during a run.
    assert_best_mono_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (best_fit >= $past(best_fit)));

    // R3: the elite slot refers to the stored score it was chosen by.
    assert_elite_score_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ELITE) |-> (gb_fit == fit_mem[gb_idx]));

    // R8: a finished run holds its results until restarted.
    assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(gen_count) && $stable(best_fit)));

    // R9: no swap happens once the limit is reached.
    assert_gen_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SWAP) |-> (gen_count < cfg_gen_limit));

    // R12: the generation counter steps by at most one per cycle while running.
    assert_gen_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((gen_count == $past(gen_count)) ||
                  (gen_count == GEN_W'($past(gen_count) + 1'b1))));

endmodule

// File: tb/ga_engine_test.sv
`timescale 1ns/1ps
module ga_engine_test;
    localparam int CW = 16;
    localparam int NP = 8;
    localparam int FW = 16;
    localparam int GW = 16;

    // Stimulus table: seed, clone rate, mutation rate, target, limit.
    // Expected outcomes follow from the requirements per row.
    localparam logic [79:0] SCEN [6] = '{
        {32'h0000_0001, 8'd0,   8'd0,   16'hFFFF, 16'd4 },  // crossover only
        {32'h0000_ACE1, 8'd255, 8'd0,   16'hFFFF, 16'd3 },  // clone, no mutation
        {32'h0000_5A5A, 8'd255, 8'd255, 16'hFFFF, 16'd3 },  // clone, full flip
        {32'h0000_1234, 8'd128, 8'd10,  16'h0000, 16'd8 },  // target met at once
        {32'h0000_BEEF, 8'd64,  8'd8,   16'h00E0, 16'd30},  // target or limit
        {32'h0000_0000, 8'd0,   8'd4,   16'hFFFF, 16'd0 }   // zero seed, limit 0
    };

    logic clk = 1'b0;
    logic rst_n, start, stop, req_valid, req_ready, fit_valid, done;
    logic [31:0] seed;
    logic [7:0] cfg_clone_rate, cfg_mut_rate;
    logic [FW-1:0] cfg_target, fit_data, best_fit;
    logic [GW-1:0] cfg_gen_limit, gen_count;
    logic [CW-1:0] req_data, best_chrom;

    always #2 clk = ~clk;

    ga_engine #(.CHROM_W(CW), .POP(NP), .FIT_W(FW), .GEN_W(GW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .seed(seed),
        .cfg_clone_rate(cfg_clone_rate), .cfg_mut_rate(cfg_mut_rate),
        .cfg_target(cfg_target), .cfg_gen_limit(cfg_gen_limit),
        .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
        .fit_valid(fit_valid), .fit_data(fit_data),
        .best_chrom(best_chrom), .best_fit(best_fit),
        .gen_count(gen_count), .done(done)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    int nreq, exp_stop;
    bit by_target, cmp_first, save_first;
    logic [FW-1:0] run_max;
    logic [CW-1:0] run_best, prev_best;
    logic [CW-1:0] cur_c [NP];
    logic [FW-1:0] cur_f [NP];
    logic [CW-1:0] prev_c [NP];
    logic [CW-1:0] first_c [NP];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Watchdog: a hung bench counts one failed check and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    function automatic logic [FW-1:0] fitf(input logic [CW-1:0] c);
        int pc = $countones(c);
        return FW'((pc << 4) | int'(c[3:0]));
    endfunction

    function automatic logic [CW-1:0] lowm(input int k);
        return CW'((32'd1 << k) - 1);
    endfunction

    // Is (c0[,c1]) some parent pair of the previous generation split at a legal cut (R5)?
    function automatic bit xo_ok(input logic [CW-1:0] a0, input logic [CW-1:0] a1,
                                 input bit pair);
        for (int a = 0; a < NP; a++)
            for (int b = 0; b < NP; b++)
                for (int k = 1; k < CW; k++) begin
                    logic [CW-1:0] m = lowm(k);
                    if (a0 == ((prev_c[a] & m) | (prev_c[b] & ~m)) &&
                        (!pair || a1 == ((prev_c[b] & m) | (prev_c[a] & ~m))))
                        return 1'b1;
                end
        return 1'b0;
    endfunction

    function automatic bit in_prev(input logic [CW-1:0] c, input bit inv);
        for (int a = 0; a < NP; a++)
            if (c == (inv ? ~prev_c[a] : prev_c[a])) return 1'b1;
        return 1'b0;
    endfunction

    task automatic end_gen(input int gi);
        int bi = 0;
        if (gi > 0) begin
            chk(cur_c[0] == prev_best, "R3 elite copied into slot 0", cur_c[0], prev_best);
            for (int s = 1; s < NP; s++) begin
                if (cfg_clone_rate == 8'd255 && cfg_mut_rate == 8'd0)
                    chk(in_prev(cur_c[s], 1'b0), "R4 R6 R7 clone child copies a parent",
                        cur_c[s], 0);
                else if (cfg_clone_rate == 8'd255 && cfg_mut_rate == 8'd255)
                    chk(in_prev(cur_c[s], 1'b1), "R4 R6 full-flip child complements a parent",
                        cur_c[s], 0);
                else if (cfg_clone_rate == 8'd0 && cfg_mut_rate == 8'd0 && (s % 2) == 1)
                    chk(xo_ok(cur_c[s], (s + 1 < NP) ? cur_c[s + 1] : '0, s + 1 < NP),
                        "R5 child pair is a single-point crossover", cur_c[s], 0);
            end
        end
        for (int s = 1; s < NP; s++)
            if (cur_f[s] > cur_f[bi]) bi = s;
        prev_best = cur_c[bi];
        if (exp_stop < 0 && (run_max >= cfg_target || gi >= int'(cfg_gen_limit))) begin
            exp_stop  = gi;
            by_target = (run_max >= cfg_target);
        end
        for (int s = 0; s < NP; s++) prev_c[s] = cur_c[s];
    endtask

    task automatic record(input logic [CW-1:0] c);
        int gi = nreq / NP;
        int slot = nreq % NP;
        logic [FW-1:0] f = fitf(c);
        if (slot == 0)
            chk(gen_count == GW'(gi), "R12 generation index at first request", gen_count, gi);
        if (save_first && nreq < NP) first_c[nreq] = c;
        if (cmp_first && nreq < NP)
            chk(c == first_c[nreq], "R13 initial population replays from seed", c, first_c[nreq]);
        cur_c[slot] = c;
        cur_f[slot] = f;
        if (f > run_max) begin
            run_max  = f;
            run_best = c;
        end
        nreq++;
        if (slot == NP - 1) end_gen(gi);
    endtask

    // Run one scenario; stop_at >= 0 pulses stop after that many requests.
    task automatic run(input logic [79:0] sc, input int stop_at);
        bit resp_pend = 0, stop_req = 0, fin = 0;
        logic [FW-1:0] resp_val = '0;
        logic [GW-1:0] g_hold;
        @(negedge clk);
        seed           = sc[79:48];
        cfg_clone_rate = sc[47:40];
        cfg_mut_rate   = sc[39:32];
        cfg_target     = sc[31:16];
        cfg_gen_limit  = sc[15:0];
        nreq = 0; exp_stop = -1; by_target = 0; run_max = '0; run_best = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < 30000; t++) begin
            @(negedge clk);
            if (done) begin
                fin = 1;
                break;
            end
            fit_valid = 1'b0;
            stop      = 1'b0;
            if (resp_pend) begin
                fit_valid = 1'b1;
                fit_data  = resp_val;
                resp_pend = 0;
            end
            if (stop_req) begin
                stop     = 1'b1;
                stop_req = 0;
            end
            req_ready = ((t % 3) != 1);
            if (req_valid && req_ready) begin
                record(req_data);
                resp_pend = 1;
                resp_val  = fitf(req_data);
                if (nreq == stop_at) stop_req = 1;
            end
        end
        fit_valid = 1'b0;
        stop      = 1'b0;
        req_ready = 1'b0;
        chk(fin, "R8 R9 R10 run reaches done", fin, 1);
        if (stop_at >= 0)
            chk(gen_count == GW'((stop_at - 1) / NP), "R10 stop ends after scored generation",
                gen_count, (stop_at - 1) / NP);
        else if (by_target)
            chk(gen_count == GW'(exp_stop), "R8 target ends the run", gen_count, exp_stop);
        else
            chk(gen_count == GW'(exp_stop), "R9 limit ends the run", gen_count, exp_stop);
        chk(nreq == (int'(gen_count) + 1) * NP, "R1 R12 requests per generation",
            nreq, (int'(gen_count) + 1) * NP);
        chk(best_fit == run_max, "R2 best score is running maximum", best_fit, run_max);
        chk(best_chrom == run_best, "R2 best chromosome is first to reach it", best_chrom, run_best);
        chk(fitf(best_chrom) == best_fit, "R2 best score matches best chromosome",
            fitf(best_chrom), best_fit);
        g_hold = gen_count;
        req_ready = 1'b1;
        repeat (5) @(negedge clk);
        chk(done && !req_valid && gen_count == g_hold, "R8 outputs hold after done",
            {done, req_valid}, 2'b10);
        req_ready = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; stop = 1'b0; req_ready = 1'b0;
        fit_valid = 1'b0; fit_data = '0; seed = '0;
        cfg_clone_rate = '0; cfg_mut_rate = '0; cfg_target = '0; cfg_gen_limit = '0;
        cmp_first = 0; save_first = 0;
        repeat (3) @(negedge clk);
        chk(!done && !req_valid, "R11 reset control outputs low", {done, req_valid}, 0);
        chk(gen_count == '0 && best_fit == '0 && best_chrom == '0,
            "R11 reset result outputs zero", {gen_count, best_fit, best_chrom}, 0);
        rst_n = 1'b1;

        // Table walk: each row checked against its requirement-derived outcome.
        for (int i = 0; i < 6; i++) begin
            save_first = (i == 0);
            cmp_first  = (i == 5);
            run(SCEN[i], -1);
        end
        save_first = 0;
        cmp_first  = 0;

        // Directed: stop pulse in the middle of the third generation (R10).
        run({32'h0BAD_F00D, 8'd100, 8'd6, 16'hFFFF, 16'd100}, 2 * NP + 3);

        // Directed: same seed restarted from done replays the population (R13).
        cmp_first = 1;
        run(SCEN[0], -1);
        cmp_first = 0;

        // Directed: reset while done returns to the reset state (R11).
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!done && !req_valid && gen_count == '0 && best_fit == '0,
            "R11 reset after a run clears outputs", {done, gen_count, best_fit}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule